// File: doc/BRIEF.md
# Streaming signed dot-product engine

This block multiplies two streams of signed 8-bit operands pair by pair and sums the products over a group of eight pairs. The sum is exact. One pair enters per clock cycle on which the valid strobe is high. The end-of-group marker arrives with the eighth pair.

Two cycles after the edge that takes the final pair, the engine raises a one-cycle result strobe. At the same time it presents the exact sum, sign-extended to a 32-bit word. The accumulator clears on the same edge that closes a group, so the first pair of the next group may follow on the very next cycle while the earlier result is still in the output pipeline. When no result is due, both outputs are held at zero. A synchronous reset drops any partial group and any result that is still in flight.

Top module: `sdot8_engine`

## Requirements
- R1: A pair is taken on a rising edge only when `rst` is 0 and `elem_vld` is 1. On a cycle with `elem_vld` at 0, `grp_end` and the data buses have no effect.
- R2: Operands are signed 8-bit two's-complement values. Each product and the group sum are exact, with no wrap, saturation, truncation or rounding.
- R3: A group is eight taken pairs. `grp_end` is 0 on pairs 0 to 6 and 1 on pair 7. The next taken pair starts a new group, including on the cycle directly after the end of the previous group.
- R4: If the final pair is taken at edge N, `dot_vld` is 1 and `dot_out` holds the sum in the cycle that is sampled at edge N+2. The result appears neither earlier nor later.
- R5: Each completed group gives exactly one cycle with `dot_vld` at 1.
- R6: On every cycle without a result, `dot_vld` is 0 and `dot_out` is 0.
- R7: `dot_out` is the group sum as a 32-bit two's-complement word, sign-extended from the internal width. The extremes are +131072 and -130048.
- R8: A reset during a group discards that group's partial sum. The first pair taken after reset is pair 0 of a new group.
- R9: While `rst` is 1, no pair is taken, any pending result is cancelled, and both outputs read 0 on the following cycle.
- R10: Taking pairs of a new group does not alter a result that is still pending from the previous group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| elem_vld | input | 1 | High when a pair is offered this cycle |
| elem_a | input | 8 | Signed operand from the first vector |
| elem_b | input | 8 | Signed operand from the second vector |
| grp_end | input | 1 | Marks the final pair of a group; read only with `elem_vld` |
| dot_vld | output | 1 | One-cycle strobe for a finished sum |
| dot_out | output | 32 | Signed group sum, zero when no result is due |

## Verification
The engine is driven with groups back to back. The groups include uniform positive operands, all-most-negative operands (both positive and negative extreme products), mixed alternating signs, and a single non-zero pair at either end of the group. Together these separate wrong sign handling, lost or shifted elements, and overflow of the internal width. Cycles that carry an end marker without the valid strobe show that the marker is ignored. A reset inside a group, and another while a sum sits in the output pipeline, show that partial sums and pending results are discarded. Every cycle's outputs are compared against a per-cycle schedule, so a result that arrives one cycle early or late, or is repeated, is caught.

// File: rtl/sdot_pkg.sv
package sdot_pkg;
  localparam int unsigned DEF_ELEM_W  = 8;
  localparam int unsigned DEF_GRP_LEN = 8;
  localparam int unsigned DEF_OUT_W   = 32;

  // Width that holds GRP_LEN exact products of two signed ELEM_W values
  function automatic int unsigned acc_width(input int unsigned ew, input int unsigned gl);
    return 2 * ew + $clog2(gl);
  endfunction
endpackage

// File: rtl/sdot_mac.sv
module sdot_mac #(
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic                     close,
  input  logic signed [ELEM_W-1:0] op_a,
  input  logic signed [ELEM_W-1:0] op_b,
  output logic signed [ACC_W-1:0]  sum_now
);
  localparam int unsigned PROD_W = 2 * ELEM_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod     = op_a * op_b;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign sum_now  = acc_q + prod_ext;

  // Closing a group reloads zero so the next group may start on the next edge
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= close ? '0 : sum_now;
    end
  end
endmodule

// File: rtl/sdot_hold.sv
module sdot_hold #(
  parameter int unsigned ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] sum_in,
  output logic                    hold_vld,
  output logic signed [ACC_W-1:0] hold_sum
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld <= 1'b0;
      hold_sum <= '0;
    end else begin
      hold_vld <= load;
      if (load) begin
        hold_sum <= sum_in;
      end
    end
  end
endmodule

// File: rtl/sdot_outreg.sv
module sdot_outreg #(
  parameter int unsigned ACC_W = 19,
  parameter int unsigned OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    src_vld,
  input  logic signed [ACC_W-1:0] src_sum,
  output logic                    out_vld,
  output logic [OUT_W-1:0]        out_data
);
  logic [OUT_W-1:0] wide;

  generate
    if (OUT_W > ACC_W) begin : g_ext
      assign wide = {{(OUT_W - ACC_W){src_sum[ACC_W-1]}}, src_sum};
    end else begin : g_same
      assign wide = src_sum;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= src_vld;
      out_data <= src_vld ? wide : '0;
    end
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_data == '0));

  generate
    if (OUT_W > ACC_W) begin : g_sx_chk
      // R7
      sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ((&out_data[OUT_W-1:ACC_W-1]) || !(|out_data[OUT_W-1:ACC_W-1])));
    end
  endgenerate
endmodule

// File: rtl/sdot8_engine.sv
module sdot8_engine #(
  parameter int unsigned ELEM_W  = sdot_pkg::DEF_ELEM_W,
  parameter int unsigned GRP_LEN = sdot_pkg::DEF_GRP_LEN,
  parameter int unsigned OUT_W   = sdot_pkg::DEF_OUT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              elem_vld,
  input  logic [ELEM_W-1:0] elem_a,
  input  logic [ELEM_W-1:0] elem_b,
  input  logic              grp_end,
  output logic              dot_vld,
  output logic [OUT_W-1:0]  dot_out
);
  localparam int unsigned ACC_W = sdot_pkg::acc_width(ELEM_W, GRP_LEN);
  localparam int unsigned POS_W = $clog2(GRP_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(GRP_LEN - 1);

  logic                    take;
  logic                    close;
  logic signed [ACC_W-1:0] sum_now;
  logic                    hold_vld;
  logic signed [ACC_W-1:0] hold_sum;
  logic [POS_W-1:0]        pos_q;

  assign take  = elem_vld & ~rst;
  assign close = take & grp_end;

  sdot_mac #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .close   (close),
    .op_a    (elem_a),
    .op_b    (elem_b),
    .sum_now (sum_now)
  );

  sdot_hold #(.ACC_W(ACC_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (close),
    .sum_in   (sum_now),
    .hold_vld (hold_vld),
    .hold_sum (hold_sum)
  );

  sdot_outreg #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .src_vld  (hold_vld),
    .src_sum  (hold_sum),
    .out_vld  (dot_vld),
    .out_data (dot_out)
  );

  // Element position inside the current group, kept for the group-length check
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (take) begin
      pos_q <= close ? '0 : pos_q + 1'b1;
    end
  end

  // R3
  grp_len_chk: assert property (@(posedge clk) disable iff (rst)
    close |-> (pos_q == LAST_POS));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(close, 2) && !$past(rst)) |-> dot_vld);

  // R4
  no_early_chk: assert property (@(posedge clk) disable iff (rst)
    dot_vld |-> $past(close, 2));

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dot_vld |=> !dot_vld);

  // R9
  rst_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dot_vld && (dot_out == '0)));
endmodule

// File: tb/sdot8_engine_bench.sv
`timescale 1ns/1ps
module sdot8_engine_bench;
  localparam int SCHED_N = 1024;
  localparam int NTAB    = 9;

  // Element i of a group sits at bits [8*i +: 8]
  localparam logic [63:0] TAB_A [NTAB] = '{
    64'h0101010101010101, 64'h8080808080808080, 64'h8080808080808080,
    64'h7F7F7F7F7F7F7F7F, 64'hF807FA05FC03FE01, 64'h0000000000000000,
    64'h7F7F7F7F7F7F7F7F, 64'h0500000000000000, 64'h0000000000000009};
  localparam logic [63:0] TAB_B [NTAB] = '{
    64'h0101010101010101, 64'h8080808080808080, 64'h7F7F7F7F7F7F7F7F,
    64'h7F7F7F7F7F7F7F7F, 64'h0202020202020202, 64'h5A5A5A5A5A5A5A5A,
    64'h8080808080808080, 64'hFD00000000000000, 64'h00000000000000F9};
  localparam int TAB_E [NTAB] = '{8, 131072, -130048, 129032, -8, 0, -130048, -15, -63};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic        gend = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic        dot_vld;
  logic [31:0] dot_out;

  int    cyc = 0;
  int    tests = 0;
  int    fails = 0;
  bit    done = 0;
  bit    sched_cnt [SCHED_N];
  bit    sched_vld [SCHED_N];
  int    sched_val [SCHED_N];
  string sched_tag [SCHED_N];

  sdot8_engine u_sdot8_engine (
    .clk      (clk),
    .rst      (rst),
    .elem_vld (vld),
    .elem_a   (a),
    .elem_b   (b),
    .grp_end  (gend),
    .dot_vld  (dot_vld),
    .dot_out  (dot_out)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Per-cycle comparison against the schedule (sampled mid-cycle)
  always @(negedge clk) begin
    if (!done && cyc < SCHED_N) begin
      if (sched_cnt[cyc]) begin
        tests++;
        if (dot_vld !== sched_vld[cyc] ||
            dot_out !== (sched_vld[cyc] ? 32'(sched_val[cyc]) : 32'd0)) begin
          fails++;
          $display("FAIL %s cyc %0d: actual vld=%b out=%0d expected vld=%b out=%0d",
                   sched_tag[cyc], cyc, dot_vld, $signed(dot_out), sched_vld[cyc],
                   sched_vld[cyc] ? sched_val[cyc] : 0);
        end
      end else if (cyc > 1 && (dot_vld !== 1'b0 || dot_out !== 32'd0)) begin
        tests++;
        fails++;
        $display("FAIL R6 (R4 R5) cyc %0d: actual vld=%b out=%0d expected vld=0 out=0",
                 cyc, dot_vld, $signed(dot_out));
      end
    end
  end

  task automatic put_pair(input logic [7:0] pa, input logic [7:0] pb,
                          input logic pv, input logic pe,
                          input int expv, input string tag);
    @(negedge clk);
    vld = pv; gend = pe; a = pa; b = pb;
    if (pv && pe && cyc + 2 < SCHED_N) begin
      sched_cnt[cyc + 2] = 1'b1;
      sched_vld[cyc + 2] = 1'b1;
      sched_val[cyc + 2] = expv;
      sched_tag[cyc + 2] = tag;
    end
  endtask

  task automatic send_group(input logic [63:0] va, input logic [63:0] vb,
                            input int expv, input string tag);
    for (int i = 0; i < 8; i++) begin
      put_pair(va[8*i +: 8], vb[8*i +: 8], 1'b1, (i == 7), expv, tag);
    end
  endtask

  // Reset cycles also offer a full closing pair, which must be refused (R1 R9)
  task automatic do_reset(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst = 1'b1; vld = 1'b1; gend = 1'b1; a = 8'h7F; b = 8'h7F;
      for (int d = 1; d <= 2; d++) begin
        if (cyc + d < SCHED_N && sched_vld[cyc + d]) begin
          sched_vld[cyc + d] = 1'b0;
          sched_tag[cyc + d] = "R9";
        end
      end
    end
    @(negedge clk);
    rst = 1'b0; vld = 1'b0; gend = 1'b0;
  endtask

  // Idle cycles with the end marker raised but no valid strobe (R1)
  task automatic idle_marker(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vld = 1'b0; gend = 1'b1; a = 8'h55; b = 8'hAA;
      if (cyc + 2 < SCHED_N) begin
        sched_cnt[cyc + 2] = 1'b1;
        sched_vld[cyc + 2] = 1'b0;
        sched_tag[cyc + 2] = "R1";
      end
    end
    @(negedge clk);
    gend = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < SCHED_N; i++) begin
      sched_cnt[i] = 1'b0; sched_vld[i] = 1'b0; sched_val[i] = 0; sched_tag[i] = "";
    end
    do_reset(3);
    tests++;
    if (dot_vld !== 1'b0 || dot_out !== 32'd0) begin
      fails++;
      $display("FAIL R9 reset state: actual vld=%b out=%0d expected vld=0 out=0",
               dot_vld, $signed(dot_out));
    end

    // Back-to-back groups from the table: R2 R3 R4 R7 R10
    for (int k = 0; k < NTAB; k++) begin
      send_group(TAB_A[k], TAB_B[k], TAB_E[k], "R2 R3 R4 R7 R10");
    end

    idle_marker(3);
    send_group(64'h0101010101010101, 64'h0101010101010101, 8, "R1");

    // R8: partial group then reset, next group counts alone
    for (int i = 0; i < 5; i++) put_pair(8'h7F, 8'h7F, 1'b1, 1'b0, 0, "R8");
    do_reset(2);
    send_group(64'h0101010101010101, 64'h0202020202020202, 16, "R8");

    // R9: reset while a result is pending
    send_group(64'h1010101010101010, 64'h1010101010101010, 2048, "R9");
    do_reset(1);

    send_group(64'hF807FA05FC03FE01, 64'h0202020202020202, -8, "R5 R3");
    idle_marker(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule